// File: doc/BRIEF.md
# DRAM Refresh and Initialization Sequencer

This block takes charge of a 16-bit asynchronous DRAM's row and column strobes for two purposes. Straight after reset it holds every strobe inactive through a long power-up pause, then fires a burst of CAS-before-RAS (CBR) refresh cycles, and only after that reports the memory as ready. From then on it keeps an interval timer. Each time the timer expires, one refresh becomes due. The block asks the access controller for the strobes and, once granted, issues all refreshes that are due, one straight after another. Row addresses come from the memory's internal counter, so the block drives no address.

The block can also put the memory into its low-power self-refresh state. When a sleep request arrives, the block asks for the strobes and runs a CBR cycle whose RAS phase does not end. It acknowledges the sleep while RAS is held low. RAS stays low for a guaranteed minimum time. After the request drops, the block gives the memory a long precharge and then runs one ordinary CBR cycle before handing the strobes back. All durations are parameters counted in clock cycles.

Top module: `dram_refresh_seq`

## Requirements
- R1: After reset, RAS, both CAS strobes and WE are high, ready_o is low and own_o is high. RAS does not fall for at least PWRUP_CYC cycles.
- R2: After the pause the block issues exactly INIT_CBR CBR cycles, then raises ready_o, which stays high. ref_req_o stays low while ready_o is low.
- R3: In every refresh cycle, both CAS strobes (always equal) fall at least CAS_SU_CYC cycles before RAS falls and stay low until RAS rises. A non-self-refresh RAS low pulse lasts exactly RAS_LO_CYC cycles. we_n_o is always high.
- R4: Between two CBR cycles that are not self refresh, RAS stays high for at least RAS_PRE_CYC cycles.
- R5: Once ready, one refresh becomes due every REF_INT_CYC cycles. ref_req_o rises when a refresh is due, so with immediate grants successive rising edges of ref_req_o are exactly REF_INT_CYC cycles apart. Each grant with one refresh due produces one CBR cycle.
- R6: At most MAX_PEND due refreshes are held. Further expiries are dropped while the count is full. On grant, every held refresh is issued back to back, and then ref_req_o drops.
- R7: own_o is high from reset until ready_o rises, and afterwards only from grant until release. RAS is low only while own_o is high.
- R8: A sleep request after ready leads to a request and, on grant, to a CBR cycle whose RAS stays low. sleep_ack_o is high while RAS is held low. RAS stays low for at least SELF_MIN_CYC cycles even if sleep_req_i drops earlier.
- R9: After sleep_req_i is low and the minimum time has passed, RAS rises. It then stays high for at least SELF_PRE_CYC cycles, after which exactly one CBR cycle follows before release.
- R10: If a refresh is due and a sleep request is present at grant, self refresh starts first and no normal CBR precedes it. The due count is cleared. No refresh becomes due during self refresh, and the interval restarts on exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_gnt_i | input | 1 | Access controller hands over the strobes |
| ref_req_o | output | 1 | Strobes wanted, held until release |
| sleep_req_i | input | 1 | Request to enter and stay in self refresh |
| sleep_ack_o | output | 1 | Memory is held in self refresh |
| own_o | output | 1 | Strobe mux selects this block |
| ready_o | output | 1 | Initialization finished |
| ras_n_o | output | 1 | Row strobe, active low |
| lcas_n_o | output | 1 | Lower-byte column strobe, active low |
| ucas_n_o | output | 1 | Upper-byte column strobe, active low |
| we_n_o | output | 1 | Write enable, held high |

## Verification
A refresh coming due and a sleep request can meet at the same grant. The bench holds off the grant until ref_req_o rises because of the timer, raises sleep_req_i in that same cycle, and then grants. It then checks three things: the first RAS fall belongs to the self-refresh pulse, exactly one extra CBR cycle follows the exit, and ref_req_o stays low for nearly a full interval afterwards. The last check shows the queue was cleared and the timer restarted.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    S_PWRUP, S_INIT, S_IDLE, S_REQ, S_RUN, S_SELF, S_EXIT
  } seq_state_e;

  typedef enum logic [2:0] {
    E_IDLE, E_SU, E_LO, E_SELF, E_PRE
  } eng_state_e;

  function automatic int unsigned max_of(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned REF_INT_CYC = 3125,
  parameter int unsigned MAX_PEND    = 4,
  localparam int unsigned TW = $clog2(REF_INT_CYC + 1),
  localparam int unsigned PW = $clog2(MAX_PEND + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic          dec_i,
  output logic [PW-1:0] pend_o
);
  localparam logic [TW-1:0] T_LAST = TW'(REF_INT_CYC - 1);
  localparam logic [PW-1:0] P_MAX  = PW'(MAX_PEND);

  logic [TW-1:0] cnt_q;
  logic [PW-1:0] pend_q;
  logic          tick;

  assign tick   = en_i && !clr_i && (cnt_q == T_LAST);
  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      if (!en_i || clr_i || tick) cnt_q <= '0;
      else                        cnt_q <= cnt_q + 1'b1;
      if (clr_i) pend_q <= '0;
      else if (tick && !dec_i && pend_q != P_MAX) pend_q <= pend_q + 1'b1;
      else if (dec_i && !tick) pend_q <= pend_q - 1'b1;
    end
  end

  a_r6_pend_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q <= P_MAX);
  a_r6_dec_only_when_due: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> pend_q != '0);
  a_r10_no_due_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !dec_i |=> pend_q <= $past(pend_q));

endmodule

// File: rtl/dram_cbr_engine.sv
module dram_cbr_engine
  import dram_ref_pkg::*;
#(
  parameter int unsigned CAS_SU_CYC   = 1,
  parameter int unsigned RAS_LO_CYC   = 5,
  parameter int unsigned RAS_PRE_CYC  = 4,
  parameter int unsigned SELF_MIN_CYC = 10000,
  parameter int unsigned SELF_PRE_CYC = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic self_i,
  input  logic wake_i,
  output logic idle_o,
  output logic self_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int unsigned CMAX = max_of(max_of(CAS_SU_CYC, RAS_LO_CYC),
                                        max_of(max_of(RAS_PRE_CYC, SELF_MIN_CYC), SELF_PRE_CYC));
  localparam int unsigned CW = $clog2(CMAX + 1);
  localparam logic [CW-1:0] SU_L = CW'(CAS_SU_CYC - 1);
  localparam logic [CW-1:0] LO_L = CW'(RAS_LO_CYC - 1);
  localparam logic [CW-1:0] PR_L = CW'(RAS_PRE_CYC - 1);
  localparam logic [CW-1:0] SM_L = CW'(SELF_MIN_CYC - 1);
  localparam logic [CW-1:0] SP_L = CW'(SELF_PRE_CYC - 1);

  eng_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          self_q, long_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= E_IDLE;
      cnt_q   <= '0;
      self_q  <= 1'b0;
      long_q  <= 1'b0;
    end else begin
      unique case (state_q)
        E_IDLE: if (start_i) begin
          state_q <= E_SU;
          cnt_q   <= '0;
          self_q  <= self_i;
        end
        E_SU: if (cnt_q == SU_L) begin
          state_q <= E_LO;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        E_LO: if (cnt_q == LO_L) begin
          state_q <= self_q ? E_SELF : E_PRE;
          long_q  <= 1'b0;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        E_SELF: if (cnt_q != SM_L) cnt_q <= cnt_q + 1'b1;
        else if (wake_i) begin
          state_q <= E_PRE;
          long_q  <= 1'b1;
          cnt_q   <= '0;
        end
        E_PRE: if (cnt_q == (long_q ? SP_L : PR_L)) begin
          state_q <= E_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: state_q <= E_IDLE;
      endcase
    end
  end

  assign idle_o  = (state_q == E_IDLE);
  assign self_o  = (state_q == E_SELF);
  assign ras_n_o = !(state_q inside {E_LO, E_SELF});
  assign cas_n_o = !(state_q inside {E_SU, E_LO, E_SELF});

  a_r3_cas_before_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> !$past(cas_n_o));
  a_r3_cas_spans_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> !cas_n_o);
  a_r9_pre_after_self: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) && long_q |-> cas_n_o);

endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
  import dram_ref_pkg::*;
#(
  parameter int unsigned PWRUP_CYC    = 20000,
  parameter int unsigned INIT_CBR     = 8,
  parameter int unsigned REF_INT_CYC  = 3125,
  parameter int unsigned MAX_PEND     = 4,
  parameter int unsigned CAS_SU_CYC   = 1,
  parameter int unsigned RAS_LO_CYC   = 5,
  parameter int unsigned RAS_PRE_CYC  = 4,
  parameter int unsigned SELF_MIN_CYC = 10000,
  parameter int unsigned SELF_PRE_CYC = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_gnt_i,
  output logic ref_req_o,
  input  logic sleep_req_i,
  output logic sleep_ack_o,
  output logic own_o,
  output logic ready_o,
  output logic ras_n_o,
  output logic lcas_n_o,
  output logic ucas_n_o,
  output logic we_n_o
);
  localparam int unsigned PWW = $clog2(PWRUP_CYC + 1);
  localparam int unsigned IW  = $clog2(INIT_CBR + 1);
  localparam int unsigned PW  = $clog2(MAX_PEND + 1);
  localparam logic [PWW-1:0] PW_LAST = PWW'(PWRUP_CYC - 1);
  localparam logic [IW-1:0]  INIT_N  = IW'(INIT_CBR);

  seq_state_e     state_q, state_d;
  logic [PWW-1:0] pw_cnt_q;
  logic [IW-1:0]  init_cnt_q;
  logic           ready_q;
  logic           eng_start, eng_self, eng_idle, eng_selfact, eng_cas_n;
  logic           tmr_en, tmr_clr, tmr_dec;
  logic [PW-1:0]  pend;

  always_comb begin
    state_d   = state_q;
    eng_start = 1'b0;
    eng_self  = 1'b0;
    tmr_clr   = 1'b0;
    tmr_dec   = 1'b0;
    unique case (state_q)
      S_PWRUP: if (pw_cnt_q == PW_LAST) state_d = S_INIT;
      S_INIT: if (eng_idle) begin
        if (init_cnt_q != INIT_N) eng_start = 1'b1;
        else                      state_d   = S_IDLE;
      end
      S_IDLE: if (sleep_req_i || pend != '0) state_d = S_REQ;
      S_REQ: if (ref_gnt_i) begin
        if (sleep_req_i) begin
          // sleep wins; internal refresh covers whatever was due
          eng_start = 1'b1;
          eng_self  = 1'b1;
          tmr_clr   = 1'b1;
          state_d   = S_SELF;
        end else state_d = S_RUN;
      end
      S_RUN: if (eng_idle) begin
        if (pend != '0) begin
          eng_start = 1'b1;
          tmr_dec   = 1'b1;
        end else state_d = S_IDLE;
      end
      S_SELF: if (eng_idle) state_d = S_EXIT;
      S_EXIT: begin
        eng_start = 1'b1;
        state_d   = S_RUN;
      end
      default: state_d = S_PWRUP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_PWRUP;
      pw_cnt_q   <= '0;
      init_cnt_q <= '0;
      ready_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_PWRUP) pw_cnt_q <= pw_cnt_q + 1'b1;
      if (state_q == S_INIT && eng_start) init_cnt_q <= init_cnt_q + 1'b1;
      if (state_q == S_INIT && state_d == S_IDLE) ready_q <= 1'b1;
    end
  end

  assign tmr_en = ready_q && (state_q != S_SELF);

  dram_ref_timer #(
    .REF_INT_CYC(REF_INT_CYC),
    .MAX_PEND   (MAX_PEND)
  ) i_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tmr_en),
    .clr_i (tmr_clr),
    .dec_i (tmr_dec),
    .pend_o(pend)
  );

  dram_cbr_engine #(
    .CAS_SU_CYC  (CAS_SU_CYC),
    .RAS_LO_CYC  (RAS_LO_CYC),
    .RAS_PRE_CYC (RAS_PRE_CYC),
    .SELF_MIN_CYC(SELF_MIN_CYC),
    .SELF_PRE_CYC(SELF_PRE_CYC)
  ) i_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(eng_start),
    .self_i (eng_self),
    .wake_i (!sleep_req_i),
    .idle_o (eng_idle),
    .self_o (eng_selfact),
    .ras_n_o(ras_n_o),
    .cas_n_o(eng_cas_n)
  );

  assign lcas_n_o    = eng_cas_n;
  assign ucas_n_o    = eng_cas_n;
  assign we_n_o      = 1'b1;
  assign ready_o     = ready_q;
  assign sleep_ack_o = eng_selfact;
  assign ref_req_o   = state_q inside {S_REQ, S_RUN, S_SELF, S_EXIT};
  assign own_o       = state_q inside {S_PWRUP, S_INIT, S_RUN, S_SELF, S_EXIT};

  a_r1_quiet_pause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == S_PWRUP |-> ras_n_o && lcas_n_o && ucas_n_o);
  a_r2_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r2_no_req_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !ref_req_o);
  a_r7_ras_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n_o |-> own_o);
  a_r8_ack_holds_ras: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_ack_o |-> !ras_n_o && ref_req_o);

endmodule

// File: tb/test_dram_refresh_seq.sv
module test_dram_refresh_seq;
  localparam int P_PWRUP = 300, P_INIT = 8, P_REF = 200, P_MAXP = 3;
  localparam int P_SU = 1, P_LO = 5, P_PRE = 4, P_SMIN = 400, P_SPRE = 11;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic ref_gnt_i = 1'b0, sleep_req_i = 1'b0;
  logic ref_req_o, sleep_ack_o, own_o, ready_o, ras_n_o, lcas_n_o, ucas_n_o, we_n_o;
  logic auto_gnt = 1'b0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, rel_cyc = 0, first_fall = -1;
  int cbr_cnt = 0, order_err = 0, su_err = 0, lo_err = 0, pre_err = 0, we_err = 0, cas_err = 0;
  int req_early = 0, ras_unowned = 0;
  int cas_run = 0, low_run = 0, high_run = 1000, last_low = 0, last_pre = 0;
  bit last_self = 0;
  logic p_ras = 1'b1;

  always #5 clk_i = ~clk_i;

  dram_refresh_seq #(
    .PWRUP_CYC(P_PWRUP), .INIT_CBR(P_INIT), .REF_INT_CYC(P_REF), .MAX_PEND(P_MAXP),
    .CAS_SU_CYC(P_SU), .RAS_LO_CYC(P_LO), .RAS_PRE_CYC(P_PRE),
    .SELF_MIN_CYC(P_SMIN), .SELF_PRE_CYC(P_SPRE)
  ) i_dram_refresh_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .ref_gnt_i(ref_gnt_i), .ref_req_o(ref_req_o),
    .sleep_req_i(sleep_req_i), .sleep_ack_o(sleep_ack_o), .own_o(own_o), .ready_o(ready_o),
    .ras_n_o(ras_n_o), .lcas_n_o(lcas_n_o), .ucas_n_o(ucas_n_o), .we_n_o(we_n_o)
  );

  // access controller model: grants while requested
  always @(negedge clk_i) ref_gnt_i <= auto_gnt && ref_req_o;

  // strobe monitor
  always @(negedge clk_i) begin
    cyc <= cyc + 1;
    if (rst_ni) begin
      if (!we_n_o) we_err <= we_err + 1;
      if (lcas_n_o != ucas_n_o) cas_err <= cas_err + 1;
      if (!ready_o && ref_req_o) req_early <= req_early + 1;
      if (!ras_n_o && !own_o) ras_unowned <= ras_unowned + 1;
      if (p_ras && !ras_n_o) begin
        if (first_fall < 0) first_fall <= cyc - rel_cyc;
        if (lcas_n_o) order_err <= order_err + 1;
        else cbr_cnt <= cbr_cnt + 1;
        if (cas_run < P_SU) su_err <= su_err + 1;
        if (high_run < (last_self ? P_SPRE : P_PRE)) pre_err <= pre_err + 1;
        last_pre <= high_run;
        low_run  <= 1;
      end else if (!ras_n_o) begin
        low_run <= low_run + 1;
        if (lcas_n_o) order_err <= order_err + 1;
      end
      if (!p_ras && ras_n_o) begin
        last_low  <= low_run;
        last_self <= (low_run > P_LO);
        if (low_run < P_LO) lo_err <= lo_err + 1;
        high_run  <= 1;
      end else if (ras_n_o) high_run <= high_run + 1;
      cas_run <= (ras_n_o && !lcas_n_o) ? cas_run + 1 : 0;
      p_ras <= ras_n_o;
    end
  end

  task automatic tick();
    @(negedge clk_i); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_ge(input string tag, input int act, input int lo);
    n_chk++;
    if (act < lo) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected>=%0d", tag, act, lo);
    end
  endtask

  task automatic wait_req_rise();
    while (ref_req_o) tick();
    while (!ref_req_o) tick();
  endtask

  task automatic wait_req_fall();
    while (!ref_req_o) tick();
    while (ref_req_o) tick();
  endtask

  task automatic t_reset();
    repeat (3) tick();
    chk("R1 ras_n in reset", ras_n_o, 1);
    chk("R1 cas_n in reset", lcas_n_o & ucas_n_o, 1);
    chk("R1 ready in reset", ready_o, 0);
    chk("R7 own in reset", own_o, 1);
    rst_ni = 1'b1;
    rel_cyc = cyc;
    tick();
    chk("R1 we_n after reset", we_n_o, 1);
  endtask

  task automatic t_pwrup_init();
    int ready_seen_own;
    while (!ready_o) tick();
    ready_seen_own = own_o;
    chk_ge("R1 pause before first RAS fall", first_fall, P_PWRUP);
    chk("R2 CBR cycles at init", cbr_cnt, P_INIT);
    chk("R2 no request before ready", req_early, 0);
    chk("R7 own released at ready", ready_seen_own, 0);
    chk("R4 init precharge violations", pre_err, 0);
  endtask

  task automatic t_periodic();
    int c0, t0;
    auto_gnt = 1'b1;
    c0 = cbr_cnt;
    wait_req_rise();
    t0 = cyc;
    while (ref_req_o) tick();
    chk("R5 one CBR per due refresh", cbr_cnt - c0, 1);
    chk("R3 normal RAS low width", last_low, P_LO);
    wait_req_rise();
    chk("R5 interval between requests", cyc - t0, P_REF);
    while (ref_req_o) tick();
    chk("R2 ready still high", ready_o, 1);
  endtask

  task automatic t_backlog();
    int c0;
    auto_gnt = 1'b0;
    wait_req_rise();
    c0 = cbr_cnt;
    repeat (4 * P_REF + 20) tick();
    chk("R7 no RAS without grant", cbr_cnt - c0, 0);
    chk("R6 request held while waiting", ref_req_o, 1);
    auto_gnt = 1'b1;
    while (ref_req_o) tick();
    chk("R6 saturated backlog issued", cbr_cnt - c0, P_MAXP);
    chk("R4 back-to-back precharge violations", pre_err, 0);
  endtask

  task automatic t_sleep();
    int c0;
    while (ref_req_o) tick();
    sleep_req_i = 1'b1;
    while (!sleep_ack_o) tick();
    c0 = cbr_cnt;
    repeat (50) tick();
    sleep_req_i = 1'b0;
    repeat (20) tick();
    chk("R8 ack held before minimum", sleep_ack_o, 1);
    chk("R8 RAS held low before minimum", ras_n_o, 0);
    while (!ras_n_o) tick();
    chk_ge("R8 self refresh RAS low time", last_low, P_SMIN);
    chk("R8 ack drops on exit", sleep_ack_o, 0);
    while (ref_req_o) tick();
    chk("R9 exactly one CBR after exit", cbr_cnt - c0, 1);
    chk_ge("R9 precharge after self refresh", last_pre, P_SPRE);
    chk("R9 exit CBR width", last_low, P_LO);
  endtask

  task automatic t_coincide();
    int c0, hits;
    auto_gnt = 1'b0;
    wait_req_rise();
    sleep_req_i = 1'b1;
    c0 = cbr_cnt;
    auto_gnt = 1'b1;
    while (!sleep_ack_o) tick();
    chk("R10 self refresh first at grant", cbr_cnt - c0, 1);
    repeat (10) tick();
    sleep_req_i = 1'b0;
    while (ref_req_o) tick();
    chk("R10 self plus one exit CBR", cbr_cnt - c0, 2);
    hits = 0;
    for (int i = 0; i < P_REF - 40; i++) begin
      tick();
      if (ref_req_o) hits++;
    end
    chk("R10 queue cleared and timer restarted", hits, 0);
    wait_req_rise();
    chk("R10 refresh resumes after exit", ref_req_o, 1);
  endtask

  task automatic run_all();
    t_reset();
    t_pwrup_init();
    t_periodic();
    t_backlog();
    t_sleep();
    t_coincide();
    repeat (5) tick();
    chk("R3 CAS not low before RAS fall", order_err, 0);
    chk("R3 CAS setup violations", su_err, 0);
    chk("R3 short RAS pulses", lo_err, 0);
    chk("R3 WE low samples", we_err, 0);
    chk("R3 CAS strobes differ", cas_err, 0);
    chk("R4 precharge violations", pre_err, 0);
    chk("R7 RAS low without ownership", ras_unowned, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1..: actual=timeout expected=completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule